// File: doc/BRIEF.md
# GPIO Bank Controller with Per-Line Interrupt Sensing

This block controls a bank of up to 32 general-purpose pins behind a simple 32-bit register bus. The bus has an address, a write strobe, write data and read data. Each line can work in one of three ways: as a general input, as a general output, or as an interrupt input. Software selects the mode of each line, its direction and its output value. It also selects, for each interrupt line, the active polarity and whether the line senses a level, a single edge or both edges. The block drives an output value and an output enable toward the pads. Incoming pins pass through a two-flop synchronizer before any logic sees them.

Each interrupt line has a per-line sensing stage, which is a small enumerated selector with three states. LEVEL is chosen when the edge-select bit is 0. ONE_EDGE is chosen when the edge-select bit is 1 and the both-edge bit is 0. ANY_EDGE is chosen when both bits are 1. Software moves a line between these states only by writing those two bits; no other transition exists.

A detected event sets a sticky status bit. Status bits are cleared by writing 1s to a clear register. Interrupts are enabled per line with two registers:
- a mask register, where writing 0 disables a line and writing 1 leaves it unchanged;
- a separate enable register, where writing 1 enables a line.

A single registered interrupt request goes high when any enabled line has its status bit set.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads zero: mode (0x00), direction (0x04), output (0x08), status (0x10), mask (0x18), polarity (0x20), sense (0x24), filter (0x28) and both-edge (0x4C). Also after reset, pad_oe is 0 and irq is 0.
- R2: pad_out equals the output register (0x08). A pad_oe bit is 1 only when its mode bit (0x00) is 0, which means general I/O, and its direction bit (0x04) is 1, which means output.
- R3: Reading the input register (0x0C) returns the pins after a two-flop synchronizer. Any bit whose pad_oe is 1 reads 0.
- R4: A line in level sensing has mode 1 and sense bit (0x24) 0. Its status bit is set in every cycle where the synchronized pin XOR its polarity bit (0x20, where 1 means active-low) is 1.
- R5: A line in single-edge sensing has mode 1, sense 1 and both-edge (0x4C) 0. With polarity 0, its status bit is set only on a rising pin. With polarity 1, it is set only on a falling pin. A steady pin does not set it again.
- R6: A line in both-edge sensing has mode 1, sense 1 and both-edge 1. Its status bit is set on every pin change in either direction.
- R7: Writing 1s to the clear register (0x14) clears those status bits. Bits written as 0 are not affected. If a set event occurs in the same cycle as a clear, the set wins.
- R8: Writing to the mask register (0x18) clears every mask bit written as 0 and keeps every bit written as 1. Writing 1s to the enable register (0x1C) sets those mask bits. Reading 0x18 returns 1 for each enabled line.
- R9: irq is 1 in the cycle after (status AND mask) is non-zero, and 0 in the cycle after it is zero.
- R10: A line in general I/O mode (mode bit 0) never sets its status bit, whatever its pin does.
- R11: Reads of an unmapped offset, or of the write-only registers 0x14 and 0x1C, return zero. Writes to an unmapped offset change nothing. The filter register (0x28) is stored and read back but has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Raw pin inputs |
| pad_out | output | 32 | Pin output values |
| pad_oe | output | 32 | Pin output enables |
| irq | output | 1 | Registered interrupt request |

## Verification
If the mask register held a wrong bit, irq would change one cycle after the matching status bit changed, and a read of 0x18 would expose it at once. If a sensing selector were in the wrong state, the status register would take a wrong value. Examples are a level line behaving like an edge line, or an edge line firing on the wrong polarity. That wrong status appears about three cycles after the pin moves: two synchronizer stages, then the status register. A clear that loses its race with a set shows up on the very next status read. The stimulus therefore holds pins steady, lets each path settle, and then reads status, mask and irq separately. This way each kind of wrong internal state shows up at a port of its own.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

    localparam int unsigned BUS_W = 32;

    // Register byte offsets
    localparam logic [7:0] OFS_MODE   = 8'h00;
    localparam logic [7:0] OFS_DIR    = 8'h04;
    localparam logic [7:0] OFS_DOUT   = 8'h08;
    localparam logic [7:0] OFS_DIN    = 8'h0C;
    localparam logic [7:0] OFS_STAT   = 8'h10;
    localparam logic [7:0] OFS_CLR    = 8'h14;
    localparam logic [7:0] OFS_MASK   = 8'h18;
    localparam logic [7:0] OFS_UNMASK = 8'h1C;
    localparam logic [7:0] OFS_POL    = 8'h20;
    localparam logic [7:0] OFS_SENSE  = 8'h24;
    localparam logic [7:0] OFS_FILT   = 8'h28;
    localparam logic [7:0] OFS_BOTH   = 8'h4C;

    typedef enum logic [1:0] {
        SENSE_LEVEL    = 2'd0,
        SENSE_ONE_EDGE = 2'd1,
        SENSE_ANY_EDGE = 2'd2
    } sense_e;

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= raw_i;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_line_sense.sv
`timescale 1ns/1ps
module gpio_line_sense
    import gpio_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic irq_mode,
    input  logic neg_logic,
    input  logic edge_sel,
    input  logic both_sel,
    output logic hit
);

    logic   prev_q;
    sense_e kind;
    logic   act_now;
    logic   act_prev;
    logic   raw_hit;

    // Previous synchronized pin value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
        end
    end

    // Selector state, chosen by the sense and both-edge bits
    always_comb begin
        if (!edge_sel) begin
            kind = SENSE_LEVEL;
        end else if (both_sel) begin
            kind = SENSE_ANY_EDGE;
        end else begin
            kind = SENSE_ONE_EDGE;
        end
    end

    assign act_now  = pin_s ^ neg_logic;
    assign act_prev = prev_q ^ neg_logic;

    always_comb begin
        unique case (kind)
            SENSE_LEVEL:    raw_hit = act_now;
            SENSE_ONE_EDGE: raw_hit = act_now & ~act_prev;
            SENSE_ANY_EDGE: raw_hit = pin_s ^ prev_q;
            default:        raw_hit = 1'b0;
        endcase
    end

    assign hit = irq_mode & raw_hit;

    // R4: an inactive level never produces an event
    p_level_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode && !edge_sel && (pin_s == neg_logic)) |-> !hit);

    // R6: a pin that holds still never produces an edge event
    p_edge_needs_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel && $stable(pin_s)) |-> !hit);

endmodule

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr_en,
    input  logic [BUS_W-1:0]     bus_wr_data,
    output logic [BUS_W-1:0]     bus_rd_data,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic                 irq
);

    localparam int unsigned N = NUM_LINES;

    logic [N-1:0] mode_q, dir_q, dout_q, pol_q, sense_q, both_q, filt_q;
    logic [N-1:0] stat_q, mask_q;
    logic         irq_q;
    logic [N-1:0] pin_s;
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;
    logic [N-1:0] wd;

    logic hit_mode, hit_dir, hit_dout, hit_clr, hit_mask, hit_unmask;
    logic hit_pol, hit_sense, hit_filt, hit_both;

    assign wd = bus_wr_data[N-1:0];

    // Write decode
    assign hit_mode   = bus_wr_en && (bus_addr == ADDR_W'(OFS_MODE));
    assign hit_dir    = bus_wr_en && (bus_addr == ADDR_W'(OFS_DIR));
    assign hit_dout   = bus_wr_en && (bus_addr == ADDR_W'(OFS_DOUT));
    assign hit_clr    = bus_wr_en && (bus_addr == ADDR_W'(OFS_CLR));
    assign hit_mask   = bus_wr_en && (bus_addr == ADDR_W'(OFS_MASK));
    assign hit_unmask = bus_wr_en && (bus_addr == ADDR_W'(OFS_UNMASK));
    assign hit_pol    = bus_wr_en && (bus_addr == ADDR_W'(OFS_POL));
    assign hit_sense  = bus_wr_en && (bus_addr == ADDR_W'(OFS_SENSE));
    assign hit_filt   = bus_wr_en && (bus_addr == ADDR_W'(OFS_FILT));
    assign hit_both   = bus_wr_en && (bus_addr == ADDR_W'(OFS_BOTH));

    gpio_in_sync #(
        .WIDTH  (N),
        .STAGES (2)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .sync_o (pin_s)
    );

    for (genvar i = 0; i < N; i++) begin : g_line
        gpio_line_sense i_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s     (pin_s[i]),
            .irq_mode  (mode_q[i]),
            .neg_logic (pol_q[i]),
            .edge_sel  (sense_q[i]),
            .both_sel  (both_q[i]),
            .hit       (set_vec[i])
        );
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            dir_q   <= '0;
            dout_q  <= '0;
            pol_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            filt_q  <= '0;
        end else begin
            if (hit_mode)  mode_q  <= wd;
            if (hit_dir)   dir_q   <= wd;
            if (hit_dout)  dout_q  <= wd;
            if (hit_pol)   pol_q   <= wd;
            if (hit_sense) sense_q <= wd;
            if (hit_both)  both_q  <= wd;
            if (hit_filt)  filt_q  <= wd;
        end
    end

    // Status and mask
    assign clr_vec = hit_clr ? wd : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | set_vec;
            if (hit_mask) begin
                mask_q <= mask_q & wd;
            end else if (hit_unmask) begin
                mask_q <= mask_q | wd;
            end
            irq_q <= |(stat_q & mask_q);
        end
    end

    // Pad side
    assign pad_out = dout_q;
    assign pad_oe  = ~mode_q & dir_q;
    assign irq     = irq_q;

    // Read mux
    always_comb begin
        bus_rd_data = '0;
        case (bus_addr)
            ADDR_W'(OFS_MODE):  bus_rd_data[N-1:0] = mode_q;
            ADDR_W'(OFS_DIR):   bus_rd_data[N-1:0] = dir_q;
            ADDR_W'(OFS_DOUT):  bus_rd_data[N-1:0] = dout_q;
            ADDR_W'(OFS_DIN):   bus_rd_data[N-1:0] = pin_s & ~pad_oe;
            ADDR_W'(OFS_STAT):  bus_rd_data[N-1:0] = stat_q;
            ADDR_W'(OFS_MASK):  bus_rd_data[N-1:0] = mask_q;
            ADDR_W'(OFS_POL):   bus_rd_data[N-1:0] = pol_q;
            ADDR_W'(OFS_SENSE): bus_rd_data[N-1:0] = sense_q;
            ADDR_W'(OFS_FILT):  bus_rd_data[N-1:0] = filt_q;
            ADDR_W'(OFS_BOTH):  bus_rd_data[N-1:0] = both_q;
            default:            bus_rd_data = '0;
        endcase
    end

    // R2: a line in interrupt mode never drives its pad
    p_oe_only_gpio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & mode_q) == '0);

    // R7: a clear without a competing set leaves the bit at 0
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((stat_q & $past(clr_vec & ~set_vec)) == '0));

    // R10: only interrupt-mode lines can newly set status
    p_gpio_no_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(mode_q)) == '0));

    // R8: a write of 0s to the mask register disables those lines and keeps the rest
    p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mask |=> (mask_q == $past(mask_q & wd)));

    // R8: a write of 1s to the enable register sets those mask bits
    p_unmask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_unmask && !hit_mask) |=> ((mask_q & $past(wd)) == $past(wd)));

    // R9: irq follows pending interrupts one cycle later
    p_irq_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & mask_q) != '0) |=> irq);
    p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & mask_q) == '0) |=> !irq);

endmodule

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;

    localparam int KIND_RD  = 0;
    localparam int KIND_IRQ = 1;
    localparam int KIND_OE  = 2;
    localparam int KIND_OUT = 3;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic [31:0] bus_rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_bank_ctrl i_gpio_bank_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .pad_in      (pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .irq         (irq)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr    = a;
        bus_wr_data = d;
        bus_wr_en   = 1'b1;
        @(negedge clk);
        bus_wr_en   = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [7:0] a,
                               input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.kind = kind;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
        @(posedge clk);
        #4;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        expect_item(KIND_RD, a, e, tag);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        expect_item(KIND_IRQ, 8'h00, {31'd0, e}, tag);
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() != 0) begin
                item_t       it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    KIND_RD:  act = bus_rd_data;
                    KIND_IRQ: act = {31'd0, irq};
                    KIND_OE:  act = pad_oe;
                    default:  act = pad_out;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        settle(3);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, 32'h0, "R1 mode");
        rd(8'h04, 32'h0, "R1 dir");
        rd(8'h08, 32'h0, "R1 dout");
        rd(8'h10, 32'h0, "R1 status");
        rd(8'h18, 32'h0, "R1 mask");
        rd(8'h20, 32'h0, "R1 polarity");
        rd(8'h24, 32'h0, "R1 sense");
        rd(8'h28, 32'h0, "R1 filter");
        rd(8'h4C, 32'h0, "R1 both");
        expect_item(KIND_OE, 8'h00, 32'h0, "R1 pad_oe");
        chk_irq(1'b0, "R1 irq");

        // R2: direction, output and mode gating
        wr(8'h04, 32'h0000_00FF);
        wr(8'h08, 32'hA5A5_00F0);
        expect_item(KIND_OE, 8'h00, 32'h0000_00FF, "R2 oe outputs");
        expect_item(KIND_OUT, 8'h00, 32'hA5A5_00F0, "R2 pad_out");
        rd(8'h04, 32'h0000_00FF, "R2 dir readback");
        wr(8'h00, 32'h0000_000F);
        expect_item(KIND_OE, 8'h00, 32'h0000_00F0, "R2 oe irq-mode gated");
        rd(8'h00, 32'h0000_000F, "R2 mode readback");

        // R3: input readback, driven lines read zero
        @(negedge clk);
        pad_in = 32'h1234_5678;
        settle(3);
        rd(8'h0C, 32'h1234_5608, "R3 input readback");

        // back to plain inputs
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h0);
        @(negedge clk);
        pad_in = 32'h0;
        settle(4);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R7 clear all");
        rd(8'h0C, 32'h0, "R3 input all low");

        // R4: level sensing, line 0
        wr(8'h00, 32'h1);
        rd(8'h10, 32'h0, "R4 inactive level");
        @(negedge clk);
        pad_in = 32'h1;
        settle(4);
        rd(8'h10, 32'h1, "R4 active high level");
        chk_irq(1'b0, "R9 masked line");
        wr(8'h1C, 32'h1);
        rd(8'h18, 32'h1, "R8 enable sets mask");
        chk_irq(1'b1, "R9 enabled pending");
        wr(8'h14, 32'h1);
        rd(8'h10, 32'h1, "R7 set wins over clear");
        @(negedge clk);
        pad_in = 32'h0;
        settle(4);
        wr(8'h14, 32'h1);
        rd(8'h10, 32'h0, "R4 cleared after release");
        chk_irq(1'b0, "R9 irq drops");
        wr(8'h20, 32'h1);
        settle(2);
        rd(8'h10, 32'h1, "R4 active low level");
        chk_irq(1'b1, "R9 irq active low");
        wr(8'h20, 32'h0);
        wr(8'h14, 32'h1);
        rd(8'h10, 32'h0, "R4 restored");
        chk_irq(1'b0, "R9 irq cleared");

        // R5: single edge, line 1
        wr(8'h00, 32'h2);
        wr(8'h24, 32'h2);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R5 start");
        @(negedge clk);
        pad_in = 32'h2;
        settle(4);
        rd(8'h10, 32'h2, "R5 rising edge");
        wr(8'h14, 32'h2);
        rd(8'h10, 32'h0, "R5 steady high no re-set");
        @(negedge clk);
        pad_in = 32'h0;
        settle(4);
        rd(8'h10, 32'h0, "R5 falling ignored");
        wr(8'h20, 32'h2);
        settle(2);
        rd(8'h10, 32'h0, "R5 polarity change no event");
        @(negedge clk);
        pad_in = 32'h2;
        settle(4);
        rd(8'h10, 32'h0, "R5 rising ignored active low");
        @(negedge clk);
        pad_in = 32'h0;
        settle(4);
        rd(8'h10, 32'h2, "R5 falling edge active low");
        wr(8'h14, 32'h2);
        wr(8'h20, 32'h0);

        // R6: both edges, line 2
        wr(8'h00, 32'h4);
        wr(8'h24, 32'h4);
        wr(8'h4C, 32'h4);
        wr(8'h14, 32'hFFFF_FFFF);
        @(negedge clk);
        pad_in = 32'h4;
        settle(4);
        rd(8'h10, 32'h4, "R6 rising");
        wr(8'h14, 32'h4);
        rd(8'h10, 32'h0, "R6 cleared");
        @(negedge clk);
        pad_in = 32'h0;
        settle(4);
        rd(8'h10, 32'h4, "R6 falling");

        // R7: zero bits of a clear have no effect
        wr(8'h14, 32'h3);
        rd(8'h10, 32'h4, "R7 other bits kept");
        wr(8'h14, 32'h0);
        rd(8'h10, 32'h4, "R7 zero write");

        // R8 / R9: mask handling
        chk_irq(1'b0, "R9 pending but masked");
        wr(8'h1C, 32'hF);
        rd(8'h18, 32'hF, "R8 enable more");
        chk_irq(1'b1, "R9 unmasked pending");
        wr(8'h18, 32'hFFFF_FFFA);
        rd(8'h18, 32'hA, "R8 zero bits disable");
        chk_irq(1'b0, "R9 masked again");
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'hA, "R8 one bits keep");
        wr(8'h1C, 32'h4);
        rd(8'h18, 32'hE, "R8 enable line 2");
        chk_irq(1'b1, "R9 re-enabled");
        wr(8'h14, 32'h4);
        chk_irq(1'b0, "R9 after clear");
        rd(8'h10, 32'h0, "R7 status zero");

        // R10: general I/O lines never set status
        wr(8'h00, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h4C, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        @(negedge clk);
        pad_in = 32'hFFFF_FFFF;
        settle(4);
        rd(8'h10, 32'h0, "R10 pins high");
        @(negedge clk);
        pad_in = 32'h0;
        settle(4);
        rd(8'h10, 32'h0, "R10 pins low");
        chk_irq(1'b0, "R10 no irq");

        // R11: unmapped and write-only offsets, filter storage
        wr(8'h08, 32'h0F0F_0000);
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, 32'h0, "R11 unmapped read");
        rd(8'h08, 32'h0F0F_0000, "R11 output kept");
        rd(8'h00, 32'h0, "R11 mode kept");
        rd(8'h18, 32'hE, "R11 mask kept");
        rd(8'h24, 32'hFFFF_FFFF, "R11 sense kept");
        rd(8'h4C, 32'hFFFF_FFFF, "R11 both kept");
        wr(8'h28, 32'hDEAD_BEEF);
        rd(8'h28, 32'hDEAD_BEEF, "R11 filter stored");
        rd(8'h10, 32'h0, "R11 filter no effect");
        rd(8'h14, 32'h0, "R11 clear reads zero");
        rd(8'h1C, 32'h0, "R11 enable reads zero");
        expect_item(KIND_OUT, 8'h00, 32'h0F0F_0000, "R11 pad_out kept");
        expect_item(KIND_OE, 8'h00, 32'h0, "R11 pad_oe kept");

        wait (sb_q.size() == 0);
        settle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule